// File: doc/BRIEF.md
# Serial Two-Zeros-Then-One Detector

This block watches a one-bit serial stream and raises a flag when it has seen two consecutive zeros followed by a one. It takes one bit on every rising clock edge. It is a four-state Moore machine, so the flag depends only on the registered state, never on the current input bit. The flag is high for exactly the one clock cycle that follows the edge on which the closing one was taken. The four states are held in two flip-flops. Idle is 00, one-zero-seen is 01, two-zeros-seen is 10 and accepting is 11. Any state value outside the table falls back to idle.

The restart rules are fixed. Because of them, detections can follow each other with only two bits in between: after an accept, a zero counts again as the first zero of a new pattern. A one received early sends the machine back to idle. Extra zeros after the second one keep it waiting in the two-zeros state.

The reset is synchronous and active high, and it returns the machine to idle. The input bit is sampled on every edge. The block has no enable and no handshake.

Top module: `zz1_detect`

## Requirements
- R1: When `rst` is high at a rising edge, the machine enters idle (00), and `match` is 0 in the cycle that follows.
- R2: In idle, an input of 0 moves to one-zero-seen (01), and an input of 1 keeps the machine in idle.
- R3: In one-zero-seen, an input of 0 moves to two-zeros-seen (10), and an input of 1 returns to idle.
- R4: In two-zeros-seen, an input of 0 stays there, and an input of 1 moves to accepting (11).
- R5: In accepting, an input of 0 moves to one-zero-seen, and an input of 1 returns to idle.
- R6: `match` is 1 exactly while the state is accepting. It changes only at rising edges and does not follow `din` between edges.
- R7: Detections can occur back to back: the stream 0,0,1,0,0,1 raises `match` after the third bit and again after the sixth bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 1 | Serial input bit, sampled on every rising edge |
| match | output | 1 | High while the accepting state is held |

## Verification
The bench targets the restart rules, where wrong logic misbehaves in specific ways:
- A design that treats a one in one-zero-seen as a fresh start would never fire on 0,1,0,0,1 in the wrong place; the bench checks that it goes back to idle instead.
- A design that sends a zero in the accepting state to idle would miss the second hit in 0,0,1,0,0,1.
- A design that leaves two-zeros-seen on a third zero would miss long runs of zeros before the one.

A random stream is compared bit by bit against a model of the table. A directed test toggles `din` between edges to catch any output that is Mealy-style rather than registered. Another directed test asserts reset while the machine is accepting, to confirm the synchronous return to idle.

// File: rtl/zz1_detect_pkg.sv
package zz1_detect_pkg;
  localparam int STATE_W = 2;

  typedef enum logic [STATE_W-1:0] {
    ST_IDLE = 2'b00,
    ST_Z1   = 2'b01,
    ST_Z2   = 2'b10,
    ST_HIT  = 2'b11
  } det_state_t;
endpackage

// File: rtl/zz1_next_state.sv
module zz1_next_state
  import zz1_detect_pkg::*;
(
  input  det_state_t cur,
  input  logic       bit_in,
  output det_state_t nxt
);
  always_comb begin
    case (cur)
      ST_IDLE: nxt = bit_in ? ST_IDLE : ST_Z1;
      ST_Z1:   nxt = bit_in ? ST_IDLE : ST_Z2;
      ST_Z2:   nxt = bit_in ? ST_HIT  : ST_Z2;
      ST_HIT:  nxt = bit_in ? ST_IDLE : ST_Z1;
      default: nxt = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/zz1_state_reg.sv
module zz1_state_reg
  import zz1_detect_pkg::*;
#(
  parameter det_state_t RESET_ST = ST_IDLE
) (
  input  logic       clk,
  input  logic       rst,
  input  det_state_t d,
  output det_state_t q
);
  always_ff @(posedge clk) begin
    if (rst) q <= RESET_ST;
    else     q <= d;
  end
endmodule

// File: rtl/zz1_out_decode.sv
module zz1_out_decode
  import zz1_detect_pkg::*;
(
  input  det_state_t cur,
  output logic       hit
);
  assign hit = (cur == ST_HIT);
endmodule

// File: rtl/zz1_detect.sv
module zz1_detect
  import zz1_detect_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic match
);
  det_state_t state_q;
  det_state_t state_d;

  zz1_next_state u_ns (
    .cur    (state_q),
    .bit_in (din),
    .nxt    (state_d)
  );

  zz1_state_reg #(.RESET_ST(ST_IDLE)) u_reg (
    .clk (clk),
    .rst (rst),
    .d   (state_d),
    .q   (state_q)
  );

  zz1_out_decode u_dec (
    .cur (state_q),
    .hit (match)
  );
endmodule

// File: rtl/zz1_detect_chk.sv
module zz1_detect_chk
  import zz1_detect_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       din,
  input logic       match,
  input det_state_t st
);
  // R1
  reset_idle_chk: assert property (@(posedge clk) rst |=> (st == ST_IDLE && !match));

  // R2
  idle_step_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE) |=> (st == ($past(din) ? ST_IDLE : ST_Z1)));

  // R3
  z1_step_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_Z1) |=> (st == ($past(din) ? ST_IDLE : ST_Z2)));

  // R4
  z2_step_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_Z2) |=> (st == ($past(din) ? ST_HIT : ST_Z2)));

  // R5
  hit_step_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_HIT) |=> (st == ($past(din) ? ST_IDLE : ST_Z1)));

  // R6
  rise_needs_one_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(match) |-> $past(din));

  // R6
  hit_single_chk: assert property (@(posedge clk) disable iff (rst)
    match |=> !match || $past(rst));
endmodule

bind zz1_detect zz1_detect_chk u_chk (
  .clk   (clk),
  .rst   (rst),
  .din   (din),
  .match (match),
  .st    (state_q)
);

// File: tb/zz1_detect_test.sv
module zz1_detect_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic din = 1'b0;
  logic match;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  zz1_detect uut (.clk(clk), .rst(rst), .din(din), .match(match));

  // {din, expected match after the edge}; covers R2..R5 and back-to-back hits (R7)
  localparam int NV = 25;
  localparam logic [1:0] VEC [NV] = '{
    2'b10, 2'b00, 2'b00, 2'b11, 2'b00, 2'b00, 2'b11, 2'b10, 2'b00, 2'b10,
    2'b00, 2'b00, 2'b00, 2'b00, 2'b11, 2'b10, 2'b10, 2'b00, 2'b00, 2'b11,
    2'b00, 2'b10, 2'b00, 2'b00, 2'b11
  };

  task automatic check(input string tag, input logic exp);
    n_chk++;
    if (match !== exp) begin
      n_bad++;
      $display("FAIL %s: match=%b expected=%b at %0t", tag, match, exp, $time);
    end
  endtask

  task automatic step(input logic b);
    din = b;
    @(posedge clk);
    @(negedge clk);
  endtask

  // model state: 0 idle, 1 one zero, 2 two zeros, 3 accept
  function automatic int model_next(input int s, input logic b);
    case (s)
      0: return b ? 0 : 1;
      1: return b ? 0 : 2;
      2: return b ? 3 : 2;
      default: return b ? 0 : 1;
    endcase
  endfunction

  initial begin
    #200000;
    n_bad++;
    n_chk++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int ms;
    @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    check("R1", 1'b0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][1]);
      check((i >= 18) ? "R7" : "R6", VEC[i][0]);
    end

    // R2: ones in idle keep idle, then 0,0,1 still hits
    step(1); step(1); step(0); step(0); step(1);
    check("R2", 1'b1);
    // R3: a one after a single zero returns to idle
    step(0); step(1); step(0); step(1);
    check("R3", 1'b0);
    // R4: long zero run waits in two-zeros state
    step(0); step(0); step(0); step(0); step(0); step(0); step(1);
    check("R4", 1'b1);
    // R5: one in accept returns to idle; following 0,1 must not hit
    step(1); step(0); step(1);
    check("R5", 1'b0);
    // R5: zero in accept counts as first zero
    step(0); step(0); step(1); step(0); step(0); step(1);
    check("R5", 1'b1);

    // R6: toggling din between edges in two-zeros state leaves match low
    step(0); step(0);
    din = 1'b1; #1; check("R6", 1'b0);
    din = 1'b0; #1; check("R6", 1'b0);
    din = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R6", 1'b1);
    din = 1'b0; #1; check("R6", 1'b1);

    // R1: synchronous reset while accepting
    step(0); step(0); step(1);
    check("R1", 1'b1);
    rst = 1'b1; din = 1'b1;
    #1; check("R1", 1'b1);
    @(posedge clk); @(negedge clk);
    check("R1", 1'b0);
    rst = 1'b0;
    step(1);
    check("R1", 1'b0);

    // R6: random stream against table model
    ms = 0;
    for (int i = 0; i < 3000; i++) begin
      logic b;
      b = 1'($urandom_range(0, 1));
      if ((i % 7) < 2) b = 1'b0;
      step(b);
      ms = model_next(ms, b);
      check("R6", ms == 3);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule